// File: doc/BRIEF.md
# Stacked Four-Mode Word Memory

This block is a small word-organised memory built from several identical 16-word by 4-bit cell arrays. All arrays share one address bus, one data-in bus and one data-out bus. Two active-low control strobes, `ctl_v` and `ctl_w`, select one of four modes: write, read, pass-through and store.

The low four address bits pick a word inside an array. The bits above them pick the array. A bank decoder hands the control strobes to the chosen array and holds every other array in store mode. Each array has an open-collector style output, modelled as a data word plus an enable flag. The shared output is the bitwise AND of all enabled arrays, and an idle array contributes all ones.

Capacity grows by 16 words for each array added through `NUM_BANKS`. The memory contents are not initialised by reset, so a word must be written before it is read.

Top module: `ramx_bank`

## Requirements
- R1: Each array holds 16 words of `WORD_W` bits. Bits [3:0] of `bus_addr` select the word, and bits [5:4] select the array (default four arrays).
- R2: With `ctl_v`=0 and `ctl_w`=0, the addressed word takes `bus_din` at every rising clock edge for as long as the mode is held. A later value of `bus_din` during the same held write replaces the earlier one. During a write, `bus_oe`=0 and `bus_q`=4'b1111.
- R3: With `ctl_v`=0 and `ctl_w`=1, `bus_q` shows the addressed stored word in the same cycle, and `bus_oe`=1.
- R4: With `ctl_v`=1 and `ctl_w`=0, `bus_q` equals `bus_din` in the same cycle, and `bus_oe`=1.
- R5: With `ctl_v`=1 and `ctl_w`=1, `bus_oe`=0, `bus_q`=4'b1111, and all stored words are held.
- R6: Arrays other than the one selected by the upper address bits are held in store mode. A write to one array leaves the same word offset in every other array unchanged.
- R7: At most one array is in a mode other than store at any time.
- R8: `bus_q` is the bitwise AND of the outputs of all enabled arrays. When no array is enabled, `bus_q` is all ones.
- R9: Pass-through and store modes never change stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst_n | input | 1 | Active-low reset; does not clear the memory contents |
| bus_addr | input | 6 | Word offset in bits [3:0], array index in bits [5:4] |
| bus_din | input | 4 | Shared write and pass-through data |
| ctl_v | input | 1 | Active-low select strobe |
| ctl_w | input | 1 | Active-low write strobe |
| bus_q | output | 4 | Wired-AND data output |
| bus_oe | output | 1 | High when some array drives the output |

## Verification
The hardest case to reach from the ports is a held write that keeps following its data. The stimulus holds the write mode across two edges with different data, and a later read shows only the second value.

The second hard case is isolation between arrays, which share offsets and buses. The bench writes distinct values at the same offset in every array and then reads each one back. It then uses pass-through and store cycles with data that differs from the stored words, and later reads show that nothing changed.

// File: rtl/ramx_pkg.sv
package ramx_pkg;
   // Mode code is {V, W}; both strobes are active low.
   typedef enum logic [1:0] {
      MODE_WRITE = 2'b00,
      MODE_READ  = 2'b01,
      MODE_PASS  = 2'b10,
      MODE_STORE = 2'b11
   } ramx_mode_e;

   function automatic ramx_mode_e ramx_mode(input logic v, input logic w);
      return ramx_mode_e'({v, w});
   endfunction
endpackage

// File: rtl/ramx_cell_array.sv
module ramx_cell_array
   import ramx_pkg::*;
#(
   parameter int WORD_W = 4,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_v,
   input  logic              sel_w,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout,
   output logic              oe
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (WORD_W < 1 || ADDR_W < 1) begin : g_bad_geom
         $error("ramx_cell_array: WORD_W and ADDR_W must be positive");
      end
   endgenerate

   logic [WORD_W-1:0] cells [DEPTH];
   ramx_mode_e        mode;

   assign mode = ramx_mode(sel_v, sel_w);

   // Level-transparent write modelled as a write on every held cycle.
   always_ff @(posedge clk) begin
      if (mode == MODE_WRITE) cells[addr] <= din;
   end

   always_comb begin
      unique case (mode)
         MODE_READ: begin
            dout = cells[addr];
            oe   = 1'b1;
         end
         MODE_PASS: begin
            dout = din;
            oe   = 1'b1;
         end
         default: begin
            dout = '1;
            oe   = 1'b0;
         end
      endcase
   end

   assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_WRITE) |=> (cells[$past(addr)] === $past(din)));

   assert_store_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_STORE) |=> (cells[$past(addr)] === $past(cells[addr])));

   assert_pass_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_PASS) |=> (cells[$past(addr)] === $past(cells[addr])));
endmodule

// File: rtl/ramx_bank_decoder.sv
module ramx_bank_decoder #(
   parameter int NUM_BANKS = 4,
   parameter int SEL_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SEL_W-1:0]     bank_idx,
   input  logic                 v_in,
   input  logic                 w_in,
   output logic [NUM_BANKS-1:0] v_out,
   output logic [NUM_BANKS-1:0] w_out
);
   logic [NUM_BANKS-1:0] active;

   generate
      for (genvar i = 0; i < NUM_BANKS; i++) begin : g_lane
         // An unselected array is forced to the store code {1,1}.
         assign v_out[i]  = (bank_idx == SEL_W'(i)) ? v_in : 1'b1;
         assign w_out[i]  = (bank_idx == SEL_W'(i)) ? w_in : 1'b1;
         assign active[i] = ~(v_out[i] & w_out[i]);
      end
   endgenerate

   assert_one_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(active));

   assert_others_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (v_in & w_in) |-> (active == '0));
endmodule

// File: rtl/ramx_wired_and.sv
module ramx_wired_and #(
   parameter int NUM_BANKS = 4,
   parameter int WORD_W    = 4
) (
   input  logic [NUM_BANKS*WORD_W-1:0] lane_q,
   input  logic [NUM_BANKS-1:0]        lane_oe,
   output logic [WORD_W-1:0]           bus_q,
   output logic                        bus_oe
);
   logic [WORD_W-1:0] chain [NUM_BANKS+1];

   assign chain[0] = '1;

   generate
      for (genvar i = 0; i < NUM_BANKS; i++) begin : g_merge
         // A disabled lane pulls nothing low.
         assign chain[i+1] = chain[i] &
            (lane_oe[i] ? lane_q[i*WORD_W +: WORD_W] : {WORD_W{1'b1}});
      end
   endgenerate

   assign bus_q  = chain[NUM_BANKS];
   assign bus_oe = |lane_oe;
endmodule

// File: rtl/ramx_bank.sv
module ramx_bank #(
   parameter int NUM_BANKS = 4,
   parameter int WORD_W    = 4,
   parameter int LOCAL_AW  = 4,
   localparam int SEL_W    = $clog2(NUM_BANKS),
   localparam int TOTAL_AW = LOCAL_AW + SEL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [TOTAL_AW-1:0] bus_addr,
   input  logic [WORD_W-1:0]   bus_din,
   input  logic                ctl_v,
   input  logic                ctl_w,
   output logic [WORD_W-1:0]   bus_q,
   output logic                bus_oe
);
   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("ramx_bank: NUM_BANKS must be a power of two, at least 2");
      end
   endgenerate

   logic [LOCAL_AW-1:0]         local_addr;
   logic [SEL_W-1:0]            bank_idx;
   logic [NUM_BANKS-1:0]        lane_v;
   logic [NUM_BANKS-1:0]        lane_w;
   logic [NUM_BANKS-1:0]        lane_oe;
   logic [NUM_BANKS*WORD_W-1:0] lane_q;

   assign local_addr = bus_addr[LOCAL_AW-1:0];
   assign bank_idx   = bus_addr[TOTAL_AW-1:LOCAL_AW];

   ramx_bank_decoder #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .bank_idx(bank_idx),
      .v_in(ctl_v), .w_in(ctl_w), .v_out(lane_v), .w_out(lane_w)
   );

   generate
      for (genvar i = 0; i < NUM_BANKS; i++) begin : g_array
         ramx_cell_array #(.WORD_W(WORD_W), .ADDR_W(LOCAL_AW)) u_cells (
            .clk(clk), .rst_n(rst_n),
            .sel_v(lane_v[i]), .sel_w(lane_w[i]),
            .addr(local_addr), .din(bus_din),
            .dout(lane_q[i*WORD_W +: WORD_W]), .oe(lane_oe[i])
         );
      end
   endgenerate

   ramx_wired_and #(.NUM_BANKS(NUM_BANKS), .WORD_W(WORD_W)) u_merge (
      .lane_q(lane_q), .lane_oe(lane_oe), .bus_q(bus_q), .bus_oe(bus_oe)
   );

   assert_idle_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> (bus_q == '1));

   assert_pass_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_v && !ctl_w) |-> (bus_oe && bus_q == bus_din));

   assert_store_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_v && ctl_w) |-> !bus_oe);
endmodule

// File: tb/ramx_bank_tb_top.sv
module ramx_bank_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [3:0] bus_din = '0;
   logic       ctl_v = 1'b1;
   logic       ctl_w = 1'b1;
   logic [3:0] bus_q;
   logic       bus_oe;

   always #4 clk = ~clk; // 125 MHz

   ramx_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_din(bus_din),
      .ctl_v(ctl_v), .ctl_w(ctl_w), .bus_q(bus_q), .bus_oe(bus_oe)
   );

   typedef struct {
      logic       oe;
      logic [3:0] q;
      string      tag;
   } exp_t;

   exp_t sb[$];
   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 0;

   // Driver: drives at the falling edge and queues the expected output.
   task automatic step(input logic v, input logic w, input logic [5:0] a,
                       input logic [3:0] d, input logic eoe,
                       input logic [3:0] eq, input string tag);
      exp_t e;
      @(negedge clk);
      ctl_v = v; ctl_w = w; bus_addr = a; bus_din = d;
      e.oe = eoe; e.q = eq; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic wr(input logic [5:0] a, input logic [3:0] d, input string tag);
      step(1'b0, 1'b0, a, d, 1'b0, 4'hF, tag);
   endtask

   task automatic rd(input logic [5:0] a, input logic [3:0] eq, input string tag);
      step(1'b0, 1'b1, a, 4'h0, 1'b1, eq, tag);
   endtask

   // Monitor: compares 2 ns after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (bus_oe !== e.oe || bus_q !== e.q) begin
               n_fail++;
               $display("FAIL %s: oe=%b q=%h expected oe=%b q=%h",
                        e.tag, bus_oe, bus_q, e.oe, e.q);
            end
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R5: idle after reset
      step(1'b1, 1'b1, 6'h00, 4'h0, 1'b0, 4'hF, "R5 idle after reset");
      // R6: same offset in every array, distinct data
      wr(6'h03, 4'h5, "R2 write a0");
      wr(6'h13, 4'hA, "R2 write a1");
      wr(6'h23, 4'h3, "R2 write a2");
      wr(6'h33, 4'hC, "R2 write a3");
      rd(6'h03, 4'h5, "R6 array0 kept");
      rd(6'h13, 4'hA, "R6 array1 kept");
      rd(6'h23, 4'h3, "R3 read array2");
      rd(6'h33, 4'hC, "R3 read array3");
      // R2: held write follows data
      wr(6'h07, 4'h1, "R2 held write first");
      wr(6'h07, 4'h9, "R2 held write second");
      rd(6'h07, 4'h9, "R2 held write result");
      // R4: pass-through, then R9 contents unchanged
      step(1'b1, 1'b0, 6'h23, 4'h6, 1'b1, 4'h6, "R4 pass-through");
      step(1'b1, 1'b0, 6'h23, 4'h0, 1'b1, 4'h0, "R4 pass zero");
      rd(6'h23, 4'h3, "R9 pass kept word");
      // R5: store with changing data
      step(1'b1, 1'b1, 6'h03, 4'h0, 1'b0, 4'hF, "R5 store quiet");
      step(1'b1, 1'b1, 6'h03, 4'hE, 1'b0, 4'hF, "R8 idle bus ones");
      rd(6'h03, 4'h5, "R9 store kept word");
      // R1: fill a full array and read back
      for (int i = 0; i < 16; i++) wr(6'h10 | 6'(i), 4'(i) ^ 4'h5, "R1 fill");
      for (int i = 0; i < 16; i++) rd(6'h10 | 6'(i), 4'(i) ^ 4'h5, "R1 readback");
      rd(6'h33, 4'hC, "R7 other array untouched");
      step(1'b1, 1'b1, 6'h00, 4'h0, 1'b0, 4'hF, "R5 final idle");
      repeat (3) @(posedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule